// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous host and an asynchronous static RAM with a 32-bit word and four byte lanes. The host presents one word request at a time, either a read or a write with a byte mask. The block turns it into a framed strobe sequence on the memory side. That side has an active-low chip select, an active-low output enable, one active-low write strobe per byte lane, a 17-bit address and a data bus. The data bus is split into an outgoing word, a drive enable and an incoming word, so the chip's pad ring can build the tristate.

Each access opens with an address setup phase in which the chip is selected but neither strobe is active, which is the output-disable state. Next comes either an output-enable window that ends with the read word being captured, or a write window in which only the masked lanes strobe low. One closing cycle then releases the strobes while the address and write data stay stable. The setup, read window and write window lengths are parameters in clock cycles. With a 50 MHz clock, the defaults of one, two and two cycles cover a 25 ns class part. The write data is driven from the first setup cycle, so data setup to the end of write is never shorter than the write window.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset, chip select, output enable and all four write strobes are high, the data drive enable is low, the ready output is high and the done pulse is low.
- R2: A request is taken only while ready is high. Ready is low from the cycle after acceptance through the closing cycle, and any request presented while ready is low leaves the strobes, address, write data and memory contents untouched.
- R3: For a read, output enable is low for exactly RD_CYC cycles, starting SETUP_CYC cycles after acceptance, and every write strobe stays high for the whole access.
- R4: The read word is the data bus value present at the last cycle of the output-enable window. It appears on the read data output in the closing cycle, together with the done pulse.
- R5: For a write, output enable stays high for the whole access. Write strobe bit i (lane i covers data bits 8i+7 down to 8i) is low for exactly WR_CYC cycles, starting SETUP_CYC cycles after acceptance, when mask bit i is 1, and stays high when mask bit i is 0.
- R6: During a write, the drive enable is high from the first setup cycle through the closing cycle, and the outgoing word equals the request data. During a read, it is low throughout.
- R7: The address output equals the request address and holds steady from the first setup cycle through the closing cycle.
- R8: Chip select is low in every cycle of an access, setup and closing cycles included. In setup and closing cycles, output enable and all write strobes are high.
- R9: The done pulse is high for exactly one cycle, the closing cycle, which is cycle SETUP_CYC plus the window length after acceptance. Ready is high again in the next cycle, with chip select high.
- R10: Output enable is never low while the drive enable is high or while any write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 32 | Write word |
| reqByteEn | input | 4 | Byte lane mask for writes |
| reqReady | output | 1 | Idle, request will be taken |
| rspValid | output | 1 | One-cycle done pulse |
| rspRdata | output | 32 | Captured read word |
| memCeN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 4 | Per-lane write strobes, active low |
| memAddr | output | 17 | Memory address |
| memDataOut | output | 32 | Word driven toward memory |
| memDataOe | output | 1 | Drive enable for memDataOut |
| memDataIn | input | 32 | Word returned by memory |

## Verification
A wrong phase or counter value shows up at the pins in the very cycle it occurs. A window that is one cycle short or long moves the output enable or a write strobe edge, and the done pulse with it. A lost write flag swaps a write strobe for an output-enable window, which the contention check and the per-cycle strobe comparison catch at once. Corruption of the latched address, mask or data only shows at the pins during the access. The bench therefore floods requests while the block is busy and reads every written word back through a behavioural memory, so a stray capture shows up in the same access or at the next read of that address.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_READ,
    S_WRITE,
    S_HOLD
  } phase_e;

  // Control to datapath: capture enables plus registered pin levels.
  typedef struct packed {
    logic load;      // latch the request this edge
    logic sample;    // latch the memory word this edge
    logic ceN;
    logic oeN;
    logic weActive;  // write window open, lanes gated by mask
    logic drive;     // drive data toward memory
    logic done;
  } strobe_t;

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int RD_CYC    = 2,
  parameter int WR_CYC    = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t ctl
);

  localparam int MAX1 = (SETUP_CYC > RD_CYC) ? SETUP_CYC : RD_CYC;
  localparam int MAXC = (MAX1 > WR_CYC) ? MAX1 : WR_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  phase_e        phase, phaseNx;
  logic [CW-1:0] cnt, cntNx;
  logic          isWr, isWrNx;
  logic          ceNQ, oeNQ, weQ, driveQ, doneQ;

  always_comb begin
    phaseNx = phase;
    cntNx   = (cnt != '0) ? cnt - 1'b1 : cnt;
    isWrNx  = isWr;
    unique case (phase)
      S_IDLE: if (reqValid) begin
        phaseNx = S_SETUP;
        cntNx   = CW'(SETUP_CYC - 1);
        isWrNx  = reqWrite;
      end
      S_SETUP: if (cnt == '0) begin
        phaseNx = isWr ? S_WRITE : S_READ;
        cntNx   = isWr ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);
      end
      S_READ, S_WRITE: if (cnt == '0) phaseNx = S_HOLD;
      S_HOLD:  phaseNx = S_IDLE;
      default: phaseNx = S_IDLE;
    endcase
  end

  // Pin levels are registered from the next phase so the strobes
  // change only at clock edges and never glitch.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= S_IDLE;
      cnt    <= '0;
      isWr   <= 1'b0;
      ceNQ   <= 1'b1;
      oeNQ   <= 1'b1;
      weQ    <= 1'b0;
      driveQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      phase  <= phaseNx;
      cnt    <= cntNx;
      isWr   <= isWrNx;
      ceNQ   <= (phaseNx == S_IDLE);
      oeNQ   <= (phaseNx != S_READ);
      weQ    <= (phaseNx == S_WRITE);
      driveQ <= isWrNx && (phaseNx != S_IDLE);
      doneQ  <= (phaseNx == S_HOLD);
    end
  end

  assign reqReady = (phase == S_IDLE);

  always_comb begin
    ctl.load     = (phase == S_IDLE) && reqValid;
    ctl.sample   = (phase == S_READ) && (cnt == '0);
    ctl.ceN      = ceNQ;
    ctl.oeN      = oeNQ;
    ctl.weActive = weQ;
    ctl.drive    = driveQ;
    ctl.done     = doneQ;
  end

  // R10: read enable never overlaps our own drive or a write strobe
  a_r10_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !oeNQ |-> (!driveQ && !weQ));

  // R8: any strobe activity happens inside a chip-select frame
  a_r8_strobe_framed: assert property (@(posedge clk) disable iff (!rstN)
    (!oeNQ || weQ) |-> !ceNQ);

  // R3: a deselected chip has every strobe and the driver released
  a_r3_idle_release: assert property (@(posedge clk) disable iff (!rstN)
    ceNQ |-> (oeNQ && !weQ && !driveQ));

  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R6: data stays driven in the cycle after the write strobe rises
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    $fell(weQ) |-> (driveQ && !ceNQ));

endmodule

// File: rtl/sramc_dp.sv
module sramc_dp
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               ctl,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqByteEn,
  input  logic [DATA_W-1:0]     memDataIn,
  output logic [DATA_W-1:0]     rspRdata,
  output logic                  rspValid,
  output logic                  memCeN,
  output logic                  memOeN,
  output logic [DATA_W/8-1:0]   memWeN,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memDataOut,
  output logic                  memDataOe
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic [LANES-1:0]  maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
      rdataQ <= '0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        maskQ  <= reqByteEn;
      end
      if (ctl.sample) rdataQ <= memDataIn;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign memWeN[g] = ~(ctl.weActive & maskQ[g]);
  end

  assign memCeN     = ctl.ceN;
  assign memOeN     = ctl.oeN;
  assign memAddr    = addrQ;
  assign memDataOut = wdataQ;
  assign memDataOe  = ctl.drive;
  assign rspRdata   = rdataQ;
  assign rspValid   = ctl.done;

  // R7: address never moves while the chip stays selected
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  // R6: write word never moves while it is being driven
  a_r6_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memDataOe && $past(memDataOe)) |-> $stable(memDataOut));

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl #(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 32,
  parameter int SETUP_CYC = 1,
  parameter int RD_CYC    = 2,
  parameter int WR_CYC    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqByteEn,
  output logic                reqReady,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                memCeN,
  output logic                memOeN,
  output logic [DATA_W/8-1:0] memWeN,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memDataOut,
  output logic                memDataOe,
  input  logic [DATA_W-1:0]   memDataIn
);

  sramc_pkg::strobe_t ctl;

  sramc_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .RD_CYC    (RD_CYC),
    .WR_CYC    (WR_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .ctl      (ctl)
  );

  sramc_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .reqByteEn  (reqByteEn),
    .memDataIn  (memDataIn),
    .rspRdata   (rspRdata),
    .rspValid   (rspValid),
    .memCeN     (memCeN),
    .memOeN     (memOeN),
    .memWeN     (memWeN),
    .memAddr    (memAddr),
    .memDataOut (memDataOut),
    .memDataOe  (memDataOe)
  );

endmodule

// File: tb/sim_sram_async_ctl.sv
`timescale 1ns/1ps
module sim_sram_async_ctl;

  localparam int AW = 17;
  localparam int DW = 32;
  localparam int NL = DW / 8;
  localparam int SU = 1;
  localparam int RW = 2;
  localparam int WW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [NL-1:0] reqByteEn = '0;
  logic          reqReady, rspValid, memCeN, memOeN, memDataOe;
  logic [DW-1:0] rspRdata, memDataOut, memDataIn;
  logic [NL-1:0] memWeN;
  logic [AW-1:0] memAddr;

  int vectors = 0;
  int misses  = 0;

  always #10 clk = ~clk;

  sram_async_ctl #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SU), .RD_CYC(RW), .WR_CYC(WW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqByteEn(reqByteEn),
    .reqReady(reqReady), .rspValid(rspValid), .rspRdata(rspRdata),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .memDataIn(memDataIn)
  );

  // Behavioural memory and bench reference
  bit [DW-1:0] model [logic [AW-1:0]];
  bit [DW-1:0] refMem [logic [AW-1:0]];
  logic [DW-1:0] rdWord = '0;
  logic sramDrive;

  assign sramDrive = !memCeN && !memOeN && (&memWeN);
  assign memDataIn = sramDrive ? rdWord : 32'h0BAD_F00D;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      rdWord <= model.exists(memAddr) ? model[memAddr] : '0;
      // R10: the memory must never drive while the controller drives or writes
      if (!memOeN) chk("R10", {31'd0, memDataOe || !(&memWeN)}, 32'd0);
      for (int l = 0; l < NL; l++) begin
        if (!memCeN && !memWeN[l]) begin
          chk("R6", {31'd0, memDataOe}, 32'd1);
          model[memAddr][8*l +: 8] = memDataOut[8*l +: 8];
        end
      end
    end
  end

  function automatic logic [DW-1:0] refRead(input logic [AW-1:0] a);
    return refMem.exists(a) ? refMem[a] : '0;
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                          input logic [NL-1:0] be);
    logic [DW-1:0] r = old;
    for (int l = 0; l < NL; l++) if (be[l]) r[8*l +: 8] = d[8*l +: 8];
    return r;
  endfunction

  // Called at a negedge with ready expected high; returns at a negedge in idle.
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [NL-1:0] be);
    int win;
    logic [DW-1:0] expRd;
    logic oeExp, doneExp;
    logic [NL-1:0] weExp;
    win = wr ? WW : RW;
    expRd = refRead(a);
    chk("R2", {31'd0, reqReady}, 32'd1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqByteEn = be;
    if (wr) refMem[a] = merge(refRead(a), d, be);
    for (int k = 0; k <= SU + win + 1; k++) begin
      @(negedge clk);
      if (k <= SU + win) begin
        oeExp   = !(!wr && k >= SU && k < SU + win);
        weExp   = (wr && k >= SU && k < SU + win) ? ~be : '1;
        doneExp = (k == SU + win);
        chk("R8", {31'd0, memCeN}, 32'd0);
        chk(wr ? "R5" : "R3", {31'd0, memOeN}, {31'd0, oeExp});
        chk(wr ? "R5" : "R3", {28'd0, memWeN}, {28'd0, weExp});
        chk("R6", {31'd0, memDataOe}, {31'd0, wr});
        if (wr) chk("R6", memDataOut, d);
        chk("R7", {15'd0, memAddr}, {15'd0, a});
        chk("R9", {31'd0, rspValid}, {31'd0, doneExp});
        chk("R2", {31'd0, reqReady}, 32'd0);
        if (!wr && doneExp) chk("R4", rspRdata, expRd);
        // R2: noise while busy must be ignored
        reqValid  = 1'b1;
        reqWrite  = 1'b1;
        reqAddr   = a ^ 17'h1;
        reqWdata  = ~d;
        reqByteEn = '1;
      end else begin
        chk("R9", {31'd0, reqReady}, 32'd1);
        chk("R9", {31'd0, memCeN}, 32'd1);
        chk("R9", {31'd0, rspValid}, 32'd0);
        reqValid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1", {31'd0, memCeN}, 32'd1);
    chk("R1", {31'd0, memOeN}, 32'd1);
    chk("R1", {28'd0, memWeN}, 32'hF);
    chk("R1", {31'd0, memDataOe}, 32'd0);
    chk("R1", {31'd0, reqReady}, 32'd1);
    chk("R1", {31'd0, rspValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // Directed corners
    access(1'b0, 17'h00000, '0, '0);                       // R4 unwritten word reads zero
    access(1'b1, 17'h00000, 32'hA5C3_1E77, 4'b1111);       // R5 full word
    access(1'b0, 17'h00000, '0, '0);                       // R4 read back
    access(1'b1, 17'h1FFFF, 32'h1122_3344, 4'b1111);       // R7 top address
    access(1'b1, 17'h1FFFF, 32'hDEAD_BEEF, 4'b0101);       // R5 lanes 0 and 2 only
    access(1'b0, 17'h1FFFF, '0, '0);                       // expect 11AD33EF
    access(1'b1, 17'h1FFFE, 32'hFFFF_FFFF, 4'b1000);       // R5 single lane 3
    access(1'b0, 17'h1FFFE, '0, '0);
    access(1'b0, 17'h00001, '0, '0);                       // R2 noise target untouched
    // Random mix
    for (int i = 0; i < 60; i++) begin
      bit wr;
      logic [AW-1:0] a;
      logic [NL-1:0] be;
      wr = ($urandom % 2) == 1;
      a  = AW'(($urandom % 8) * 32'h2491);
      be = NL'($urandom % 15) + 1'b1;
      access(wr, a, $urandom, be);
      if (($urandom % 4) == 0) repeat ($urandom % 3) @(negedge clk);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule